// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch

This block holds eight level-sensitive storage bits arranged as two banks of four, bank a and bank b. The banks share one binary address and two active-low controls: a master clear and a write enable. Each bank has its own data input and shows every stored bit on its own parallel output. The block has no clock. A bit that is being written is transparent, so its output follows the data input for as long as the write lasts.

The two control levels select one of four modes. The mode decoder is written as an enumerated machine and has no transitions of its own; the mode changes as soon as the control levels change. MODE_WRITE is clear high with enable low: the addressed bit in each bank is written. MODE_HOLD is clear high with enable high: nothing changes. MODE_DECODE is clear low with enable low: the block works as a dual 1-of-4 decoder. MODE_CLEAR is clear low with enable high: all bits are forced to zero. Any mode can follow any other.

In MODE_DECODE the stored bits are loaded with the decoded pattern. After a change to MODE_HOLD, that pattern stays on the outputs. The block can serve as a serial-to-parallel register with random access, as two demultiplexers, or as two active-high decoders. The enable should stay high while the address changes, so that no bit passes through on the way.

Top module: `dal_dual_latch`

## Requirements
- R1: In MODE_CLEAR (clear_n=0, wr_en_n=1), all eight outputs are 0, whatever the address and data inputs are.
- R2: In MODE_WRITE (clear_n=1, wr_en_n=0), the addressed bit of each bank follows that bank's data input while the mode lasts. The write is transparent.
- R3: In MODE_WRITE, every bit that is not addressed keeps its earlier value.
- R4: In MODE_HOLD (clear_n=1, wr_en_n=1), all eight bits keep their values. Changes on the address or data inputs have no effect.
- R5: In MODE_DECODE (clear_n=0, wr_en_n=0), the addressed output of each bank equals that bank's data input, and every other output is 0.
- R6: The address is decoded as a binary number. Value k (0 to 3) selects output bit k, so addr=2'b10 selects q_a[2] and q_b[2]. The same address applies to both banks at once.
- R7: MODE_DECODE and MODE_CLEAR load the stored bits with the values they drive. After a change to MODE_HOLD, the outputs keep showing those values.
- R8: The banks are independent. The data input of bank a never changes a bit of bank b, and the data input of bank b never changes a bit of bank a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clear_n | input | 1 | Active-low master clear; its level selects the mode together with wr_en_n |
| wr_en_n | input | 1 | Active-low write enable |
| addr | input | 2 | Bit address shared by both banks |
| d_a | input | 1 | Data input of bank a |
| d_b | input | 1 | Data input of bank b |
| q_a | output | 4 | Stored bits of bank a, with bit k at address k |
| q_b | output | 4 | Stored bits of bank b, with bit k at address k |

## Verification
The bench uses the default ADDR_W of 2, which gives four bits per bank. With that size, every address can be visited in every mode, with both data levels and with different data on the two banks. The bench keeps its own model of the eight stored bits and compares the outputs against it after each step. It also covers the mode changes that depend on stored state: a write changing to hold with the address moving, a decode changing to hold, and a clear changing to hold.

// File: rtl/dal_pkg.sv
`timescale 1ns/1ps
package dal_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE  = 2'b00,
        MODE_HOLD   = 2'b01,
        MODE_DECODE = 2'b10,
        MODE_CLEAR  = 2'b11
    } mode_e;
endpackage

// File: rtl/dal_mode_dec.sv
`timescale 1ns/1ps
module dal_mode_dec
    import dal_pkg::*;
(
    input  logic  clear_n,
    input  logic  wr_en_n,
    output mode_e mode
);
    // The mode is set by the control levels alone, with no register.
    always_comb begin
        unique case ({clear_n, wr_en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DECODE;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/dal_addr_dec.sv
`timescale 1ns/1ps
module dal_addr_dec #(
    parameter int ADDR_W = 2,
    localparam int BITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BITS-1:0]   sel
);
    for (genvar i = 0; i < BITS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/dal_bank.sv
`timescale 1ns/1ps
module dal_bank
    import dal_pkg::*;
#(
    parameter int BITS = 4
) (
    input  mode_e           mode,
    input  logic [BITS-1:0] sel,
    input  logic            d,
    output logic [BITS-1:0] q
);
    logic [BITS-1:0] store;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        always_latch begin
            unique case (mode)
                MODE_CLEAR:  store[i] <= 1'b0;
                MODE_DECODE: store[i] <= sel[i] & d;
                MODE_WRITE:  if (sel[i]) store[i] <= d;
                MODE_HOLD:   ;
            endcase
        end
    end

    assign q = store;
endmodule

// File: rtl/dal_dual_latch.sv
`timescale 1ns/1ps
module dal_dual_latch
    import dal_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int BITS = 1 << ADDR_W
) (
    input  logic              clear_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              d_a,
    input  logic              d_b,
    output logic [BITS-1:0]   q_a,
    output logic [BITS-1:0]   q_b
);
    localparam int BANKS = 2;

    mode_e           mode;
    logic [BITS-1:0] sel;
    logic [BANKS-1:0] d_bank;
    logic [BITS-1:0] q_bank [BANKS];

    dal_mode_dec u_mode (
        .clear_n (clear_n),
        .wr_en_n (wr_en_n),
        .mode    (mode)
    );

    dal_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    assign d_bank = {d_b, d_a};

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        dal_bank #(.BITS(BITS)) u_bank (
            .mode (mode),
            .sel  (sel),
            .d    (d_bank[g]),
            .q    (q_bank[g])
        );
    end

    assign q_a = q_bank[0];
    assign q_b = q_bank[1];
endmodule

// File: rtl/dal_dual_latch_chk.sv
`timescale 1ns/1ps
module dal_dual_latch_chk #(
    parameter int ADDR_W = 2,
    localparam int BITS = 1 << ADDR_W
) (
    input logic              clear_n,
    input logic              wr_en_n,
    input logic [ADDR_W-1:0] addr,
    input logic              d_a,
    input logic              d_b,
    input logic [BITS-1:0]   q_a,
    input logic [BITS-1:0]   q_b
);
    always_comb begin
        if (!clear_n && wr_en_n) begin
            // R1
            clear_low_chk: assert (q_a == '0 && q_b == '0)
                else $error("clear mode drives a nonzero output");
        end
        if (clear_n && !wr_en_n) begin
            // R2
            write_follow_chk: assert (q_a[addr] == d_a && q_b[addr] == d_b)
                else $error("addressed bit does not follow data in write mode");
        end
        if (!clear_n && !wr_en_n) begin
            // R5
            decode_pattern_chk: assert (q_a == (BITS'(d_a) << addr) && q_b == (BITS'(d_b) << addr))
                else $error("decode mode pattern wrong");
            // R5
            decode_onehot_chk: assert ($onehot0(q_a) && $onehot0(q_b))
                else $error("decode mode drives more than one output");
        end
    end
endmodule

bind dal_dual_latch dal_dual_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clear_n (clear_n),
    .wr_en_n (wr_en_n),
    .addr    (addr),
    .d_a     (d_a),
    .d_b     (d_b),
    .q_a     (q_a),
    .q_b     (q_b)
);

// File: tb/tb_dal_dual_latch.sv
`timescale 1ns/1ps
module tb_dal_dual_latch;
    localparam int ADDR_W = 2;
    localparam int BITS = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              clear_n, wr_en_n, d_a, d_b;
    logic [ADDR_W-1:0] addr;
    logic [BITS-1:0]   q_a, q_b;
    logic [BITS-1:0]   m_a, m_b;
    int                errors = 0;
    int                checks = 0;
    bit                done = 1'b0;

    always #2 clk = ~clk;

    dal_dual_latch #(.ADDR_W(ADDR_W)) dut (
        .clear_n (clear_n),
        .wr_en_n (wr_en_n),
        .addr    (addr),
        .d_a     (d_a),
        .d_b     (d_b),
        .q_a     (q_a),
        .q_b     (q_b)
    );

    // Reference model of the stored bits, written from the requirements.
    task automatic model_step();
        if (!clear_n && wr_en_n) begin
            m_a = '0; m_b = '0;
        end else if (!clear_n && !wr_en_n) begin
            m_a = '0; m_b = '0;
            m_a[addr] = d_a; m_b[addr] = d_b;
        end else if (clear_n && !wr_en_n) begin
            m_a[addr] = d_a; m_b[addr] = d_b;
        end
    endtask

    task automatic apply(input logic c, input logic e, input int a,
                         input logic da, input logic db, input string req);
        @(negedge clk);
        clear_n = c; wr_en_n = e; addr = ADDR_W'(a); d_a = da; d_b = db;
        model_step();
        @(posedge clk);
        #1;
        checks++;
        if (q_a !== m_a || q_b !== m_b) begin
            errors++;
            $display("FAIL %s: q_a=%b q_b=%b expected q_a=%b q_b=%b",
                     req, q_a, q_b, m_a, m_b);
        end
    endtask

    task automatic t_clear();
        apply(0, 1, 0, 0, 0, "R1 reset state");
        apply(0, 1, 3, 1, 1, "R1 clear ignores addr/data");
        apply(0, 1, 1, 1, 0, "R1 clear ignores addr/data");
    endtask

    task automatic t_write();
        for (int a = 0; a < BITS; a++)
            apply(1, 0, a, a[0], ~a[0], "R2 R6 R8 write per address");
        apply(1, 0, 2, 1, 1, "R2 transparent follow");
        apply(1, 0, 2, 0, 1, "R2 R8 transparent follow bank a only");
        apply(1, 0, 2, 1, 0, "R2 R8 transparent follow bank b only");
        apply(1, 0, 0, 1, 1, "R3 others unchanged");
    endtask

    task automatic t_hold();
        apply(1, 1, 0, 1, 1, "R4 enter hold");
        for (int a = 0; a < BITS; a++) begin
            apply(1, 1, a, 0, 1, "R4 hold ignores inputs");
            apply(1, 1, a, 1, 0, "R4 hold ignores inputs");
        end
    endtask

    task automatic t_decode();
        for (int a = 0; a < BITS; a++) begin
            apply(0, 0, a, 1, 0, "R5 R6 decode bank a");
            apply(0, 0, a, 0, 1, "R5 R8 decode bank b");
            apply(0, 0, a, 1, 1, "R5 decode both");
        end
        apply(0, 0, 1, 1, 1, "R5 decode before hold");
        apply(1, 1, 3, 0, 0, "R7 decode pattern retained in hold");
        apply(1, 1, 0, 1, 1, "R7 R4 pattern kept while inputs move");
    endtask

    task automatic t_clear_load();
        apply(1, 0, 3, 1, 1, "R2 write before clear");
        apply(0, 1, 3, 1, 1, "R1 clear after write");
        apply(1, 1, 3, 1, 1, "R7 clear retained in hold");
        apply(1, 0, 1, 1, 0, "R3 R8 write after clear");
        apply(1, 1, 1, 0, 1, "R4 final hold");
    endtask

    initial begin
        clear_n = 1'b0; wr_en_n = 1'b1; addr = '0; d_a = 1'b0; d_b = 1'b0;
        m_a = '0; m_b = '0;
        t_clear();
        t_write();
        t_hold();
        t_decode();
        t_clear_load();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule